// File: doc/BRIEF.md
# I2C Register Target with Strap-Selected Address

This block is the serial front end of a register bank. It watches an open-drain two-wire bus, finds START and STOP conditions and shifts bytes in and out MSB first. It turns each accepted transfer into accesses on a simple parallel register bus. The device address is one of two fixed 7-bit values. A strap pin picks the value; the pin is sampled once when reset is released and is held until the next reset.

A transfer begins with the device address and one subaddress byte, which selects a register. The register side tells the block whether the selected register is 8 or 16 bits wide, so one subaddress space can hold both sizes. Wide registers move as two bytes with the high byte first. The write strobe fires once, when the whole word is complete.

A read needs two phases. The first is a write-addressed phase that carries the subaddress. A repeated START then brings in the read address. If a STOP falls between the two phases, the read address is refused. The register side can slow the bus by asserting a hold request. The block answers it by keeping SCL low.

Top module: `i2c_strap_regtarget`

## Requirements
- R1: With the strap latched low the block acknowledges device address 0x43 (write byte 0x86, read byte 0x87); with it latched high it acknowledges 0x47 (write byte 0x8E, read byte 0x8F); any other address byte gets no acknowledge and SDA is never pulled low for it.
- R2: The strap level is taken on the first clock after reset is released; later changes of the strap pin have no effect on the acknowledged address until the next reset.
- R3: In a write, the device write address, the subaddress byte and each accepted data byte are acknowledged by SDA held low during the ninth SCL pulse.
- R4: For a register with `rb_wide` low, one data byte produces exactly one `rb_we` pulse with `rb_addr` equal to the subaddress and `rb_wdata` equal to {8'h00, byte}.
- R5: For a register with `rb_wide` high, the first data byte is the high byte; no strobe follows it, and a single `rb_we` pulse follows the second byte with `rb_wdata` = {first, second}.
- R6: After a subaddress phase and a repeated START carrying the read address, the block returns the register MSB first: for a wide register the high byte, then on master ACK the low byte; for a narrow register `rb_rdata[7:0]` only.
- R7: When the master NACKs a read byte, or after the last byte of the register, the block releases SDA and drives nothing until the next START.
- R8: A STOP received between the subaddress phase and the read address makes the read address go unacknowledged.
- R9: A STOP or a START received in the middle of a wide write discards the partly received word: no strobe is issued for it, and the next data byte is again taken as a high byte.
- R10: While `rb_hold` is high during an addressed transfer, the block holds SCL low (`scl_oe` high) from the next SCL fall and lets it go after `rb_hold` drops.
- R11: The SDA drive changes only while the synchronised SCL is low.
- R12: Data bytes beyond the width of the addressed register are not acknowledged and cause no strobe.
- R13: `rb_we` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 1 | Address select pin, latched when reset is released |
| scl_i | input | 1 | SCL line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low |
| rb_addr | output | 8 | Register subaddress |
| rb_wdata | output | 16 | Write data, high byte in bits 15:8 |
| rb_we | output | 1 | Write strobe, one cycle |
| rb_rdata | input | 16 | Read data of the register at `rb_addr` |
| rb_wide | input | 1 | The register at `rb_addr` is 16 bits wide |
| rb_hold | input | 1 | Register side not ready; stretch the clock |

## Verification
On every cycle the assertions check three things: SDA moves only during the SCL low phase, a STOP always leaves SDA released, and the write strobe never lasts more than one cycle. They also check that a stretch only starts under a hold request and that the latched address stays fixed once taken. The bench scenarios show the behaviour that depends on a sequence of bytes. This covers address matching for both strap levels, how the strobe is placed for narrow and wide registers, the byte order of reads, refusal of a read after a STOP, the loss of half-written words on an abort, and the NACK of surplus bytes.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned BITCNT_W = 4;
   localparam logic [BITCNT_W-1:0] CNT_ACK_DUE = 4'd8;
   localparam logic [BITCNT_W-1:0] CNT_ACK_BIT = 4'd9;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_SUB,
      ST_WR,
      ST_RD
   } xfer_st_t;

   typedef enum logic [1:0] {
      WB_NONE,
      WB_HIGH,
      WB_DONE
   } wr_progress_t;
endpackage

// File: rtl/i2cr_line_sampler.sv
module i2cr_line_sampler #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2cr_line_sampler: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_q    <= scl_pipe[STAGES-1];
         sda_q    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s     = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cr_addr_strap.sv
module i2cr_addr_strap #(
   parameter logic [6:0] ADDR_LO = 7'h43,
   parameter logic [6:0] ADDR_HI = 7'h47
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       strap_i,
   output logic [6:0] dev_addr
);
   generate
      if (ADDR_LO == ADDR_HI) begin : g_same_addr
         $error("i2cr_addr_strap: the two strap addresses must differ");
      end
   endgenerate

   logic taken;
   logic sel_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taken  <= 1'b0;
         sel_hi <= 1'b0;
      end else if (!taken) begin
         taken  <= 1'b1;
         sel_hi <= strap_i;
      end
   end

   assign dev_addr = sel_hi ? ADDR_HI : ADDR_LO;

   // R2: once taken, the address never moves until reset
   a_r2_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      $past(taken) |-> $stable(dev_addr));
endmodule

// File: rtl/i2c_strap_regtarget.sv
module i2c_strap_regtarget
   import i2cr_pkg::*;
#(
   parameter int unsigned SUB_W       = 8,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [6:0]  ADDR_LO     = 7'h43,
   parameter logic [6:0]  ADDR_HI     = 7'h47
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_i,
   input  logic              scl_i,
   output logic              scl_oe,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [SUB_W-1:0]  rb_addr,
   output logic [DATA_W-1:0] rb_wdata,
   output logic              rb_we,
   input  logic [DATA_W-1:0] rb_rdata,
   input  logic              rb_wide,
   input  logic              rb_hold
);
   localparam int unsigned HALF = DATA_W / 2;

   generate
      if (DATA_W != 2 * BYTE_W) begin : g_bad_data_w
         $error("i2c_strap_regtarget: DATA_W must be two bytes");
      end
      if (SUB_W != BYTE_W) begin : g_bad_sub_w
         $error("i2c_strap_regtarget: SUB_W must be one byte");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [6:0] dev_addr;

   i2cr_line_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   i2cr_addr_strap #(.ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)) u_strap (
      .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .dev_addr(dev_addr)
   );

   xfer_st_t              st;
   wr_progress_t          wprog;
   logic [BITCNT_W-1:0]   bitcnt;
   logic [BYTE_W-1:0]     shreg;
   logic [BYTE_W-1:0]     tx;
   logic [BYTE_W-1:0]     hi_byte;
   logic [SUB_W-1:0]      subaddr;
   logic                  sub_valid;
   logic                  rd_dir;
   logic                  more_lo;
   logic                  mack;
   logic                  sda_drv;
   logic                  stretch;
   logic                  scl_hold_r;
   logic                  we_r;
   logic [DATA_W-1:0]     wdata_r;

   logic pend, hold_now, go, addr_hit;
   logic [BYTE_W-1:0] first_byte;

   assign pend       = scl_fall | stretch;
   assign hold_now   = rb_hold & (st != ST_IDLE);
   assign go         = pend & ~hold_now;
   assign addr_hit   = (shreg[BYTE_W-1:1] == dev_addr) && (!shreg[0] || sub_valid);
   assign first_byte = rb_wide ? rb_rdata[DATA_W-1:HALF] : rb_rdata[HALF-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         wprog      <= WB_NONE;
         bitcnt     <= '0;
         shreg      <= '0;
         tx         <= '0;
         hi_byte    <= '0;
         subaddr    <= '0;
         sub_valid  <= 1'b0;
         rd_dir     <= 1'b0;
         more_lo    <= 1'b0;
         mack       <= 1'b0;
         sda_drv    <= 1'b0;
         stretch    <= 1'b0;
         scl_hold_r <= 1'b0;
         we_r       <= 1'b0;
         wdata_r    <= '0;
      end else begin
         we_r       <= 1'b0;
         stretch    <= pend & hold_now;
         scl_hold_r <= (pend & hold_now) | (stretch & go);
         if (start_det) begin
            st      <= ST_ADDR;
            bitcnt  <= '0;
            sda_drv <= 1'b0;
            wprog   <= WB_NONE;
            hi_byte <= '0;
         end else if (stop_det) begin
            st        <= ST_IDLE;
            sub_valid <= 1'b0;
            sda_drv   <= 1'b0;
            wprog     <= WB_NONE;
            hi_byte   <= '0;
         end else if (scl_rise) begin
            if (st != ST_IDLE && bitcnt < CNT_ACK_DUE) begin
               shreg  <= {shreg[BYTE_W-2:0], sda_s};
               bitcnt <= bitcnt + 1'b1;
            end
            if (st == ST_RD && bitcnt == CNT_ACK_BIT) begin
               mack <= ~sda_s;
            end
         end else if (go) begin
            unique case (st)
               ST_ADDR: begin
                  if (bitcnt == CNT_ACK_DUE) begin
                     if (addr_hit) begin
                        sda_drv <= 1'b1;
                        rd_dir  <= shreg[0];
                        bitcnt  <= CNT_ACK_BIT;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end else if (bitcnt == CNT_ACK_BIT) begin
                     bitcnt <= '0;
                     if (rd_dir) begin
                        st      <= ST_RD;
                        more_lo <= rb_wide;
                        sda_drv <= ~first_byte[BYTE_W-1];
                        tx      <= {first_byte[BYTE_W-2:0], 1'b0};
                     end else begin
                        st      <= ST_SUB;
                        sda_drv <= 1'b0;
                     end
                  end
               end
               ST_SUB: begin
                  if (bitcnt == CNT_ACK_DUE) begin
                     subaddr   <= shreg;
                     sub_valid <= 1'b1;
                     sda_drv   <= 1'b1;
                     bitcnt    <= CNT_ACK_BIT;
                  end else if (bitcnt == CNT_ACK_BIT) begin
                     sda_drv <= 1'b0;
                     bitcnt  <= '0;
                     st      <= ST_WR;
                     wprog   <= WB_NONE;
                  end
               end
               ST_WR: begin
                  if (bitcnt == CNT_ACK_DUE) begin
                     if (wprog == WB_DONE) begin
                        st <= ST_IDLE;
                     end else begin
                        sda_drv <= 1'b1;
                        bitcnt  <= CNT_ACK_BIT;
                        if (wprog == WB_NONE && rb_wide) begin
                           hi_byte <= shreg;
                           wprog   <= WB_HIGH;
                        end else begin
                           we_r    <= 1'b1;
                           wdata_r <= (wprog == WB_HIGH) ? {hi_byte, shreg}
                                                          : {{HALF{1'b0}}, shreg};
                           wprog   <= WB_DONE;
                        end
                     end
                  end else if (bitcnt == CNT_ACK_BIT) begin
                     sda_drv <= 1'b0;
                     bitcnt  <= '0;
                  end
               end
               ST_RD: begin
                  if (bitcnt == CNT_ACK_DUE) begin
                     sda_drv <= 1'b0;
                     bitcnt  <= CNT_ACK_BIT;
                  end else if (bitcnt == CNT_ACK_BIT) begin
                     if (mack && more_lo) begin
                        more_lo <= 1'b0;
                        bitcnt  <= '0;
                        sda_drv <= ~rb_rdata[HALF-1];
                        tx      <= {rb_rdata[HALF-2:0], 1'b0};
                     end else begin
                        sda_drv <= 1'b0;
                        st      <= ST_IDLE;
                     end
                  end else if (bitcnt != '0) begin
                     sda_drv <= ~tx[BYTE_W-1];
                     tx      <= {tx[BYTE_W-2:0], 1'b0};
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe   = sda_drv;
   assign scl_oe   = scl_hold_r;
   assign rb_addr  = subaddr;
   assign rb_we    = we_r;
   assign rb_wdata = wdata_r;

   // R11: SDA drive moves only in the SCL low phase
   a_r11_sda_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);

   // R7: a STOP always leaves SDA released
   a_r7_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

   // R13: write strobe lasts one cycle
   a_r13_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rb_we |=> !rb_we);

   // R10: a stretch only begins under a hold request
   a_r10_hold_only: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_oe) |-> $past(rb_hold));

   // R5: a strobe for a wide register is never issued in the high-byte step
   a_r5_wide_single: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_we && rb_wide) |-> $past(wprog) == WB_HIGH);
endmodule

// File: tb/test_i2c_strap_regtarget.sv
`timescale 1ns/1ps
module test_i2c_strap_regtarget;
   localparam int Q = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic strap = 1'b0;
   logic m_scl_low = 1'b0;
   logic m_sda_low = 1'b0;
   logic hold = 1'b0;
   logic scl_oe, sda_oe, rb_we;
   logic [7:0] rb_addr;
   logic [15:0] rb_wdata, rb_rdata;
   logic [15:0] regs [256];
   int n_chk = 0;
   int n_fail = 0;
   int we_cnt = 0;
   logic [7:0] last_addr = '0;
   logic [15:0] last_data = '0;

   wire scl_bus = !(m_scl_low | scl_oe);
   wire sda_bus = !(m_sda_low | sda_oe);
   wire rb_wide = rb_addr[7];
   assign rb_rdata = regs[rb_addr];

   always #2.5 clk = ~clk;

   i2c_strap_regtarget i_i2c_strap_regtarget (
      .clk(clk), .rst_n(rst_n), .strap_i(strap),
      .scl_i(scl_bus), .scl_oe(scl_oe), .sda_i(sda_bus), .sda_oe(sda_oe),
      .rb_addr(rb_addr), .rb_wdata(rb_wdata), .rb_we(rb_we),
      .rb_rdata(rb_rdata), .rb_wide(rb_wide), .rb_hold(hold)
   );

   initial for (int i = 0; i < 256; i++) regs[i] = 16'h0;

   always @(posedge clk) begin
      if (rb_we) begin
         regs[rb_addr] <= rb_wdata;
         we_cnt    <= we_cnt + 1;
         last_addr <= rb_addr;
         last_data <= rb_wdata;
      end
   end

   task automatic report;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_q;
      repeat (Q) @(negedge clk);
   endtask

   task automatic wait_high;
      while (!scl_bus) @(negedge clk);
   endtask

   task automatic m_start;
      m_sda_low = 1'b0; wait_q;
      m_scl_low = 1'b0; wait_high; wait_q;
      m_sda_low = 1'b1; wait_q;
      m_scl_low = 1'b1; wait_q;
   endtask

   task automatic m_stop;
      m_sda_low = 1'b1; wait_q;
      m_scl_low = 1'b0; wait_high; wait_q;
      m_sda_low = 1'b0; wait_q;
   endtask

   task automatic put_bit(input logic b);
      m_sda_low = ~b; wait_q;
      m_scl_low = 1'b0; wait_high; wait_q; wait_q;
      m_scl_low = 1'b1; wait_q;
   endtask

   task automatic get_bit(output logic b);
      m_sda_low = 1'b0; wait_q;
      m_scl_low = 1'b0; wait_high; wait_q;
      b = sda_bus; wait_q;
      m_scl_low = 1'b1; wait_q;
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      logic x;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(x);
      ack = ~x;
   endtask

   task automatic get_byte(output logic [7:0] v, input logic ack);
      logic x;
      for (int i = 7; i >= 0; i--) begin
         get_bit(x);
         v[i] = x;
      end
      put_bit(~ack);
   endtask

   task automatic do_reset(input logic s);
      rst_n = 1'b0; strap = s;
      m_scl_low = 1'b0; m_sda_low = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R7 reset sda_oe", sda_oe, 0);
      chk("R10 reset scl_oe", scl_oe, 0);
      chk("R4 reset no strobe", we_cnt, 0);
   endtask

   task automatic t_write8;
      logic a0, a1, a2;
      int base = we_cnt;
      m_start; send_byte(8'h86, a0); send_byte(8'h12, a1); send_byte(8'hA5, a2); m_stop;
      chk("R3 addr ack", a0, 1);
      chk("R3 sub ack", a1, 1);
      chk("R3 data ack", a2, 1);
      chk("R4 one strobe", we_cnt - base, 1);
      chk("R4 addr", last_addr, 8'h12);
      chk("R4 data", last_data, 16'h00A5);
   endtask

   task automatic t_write16;
      logic a0, a1, a2, a3;
      int base = we_cnt;
      m_start; send_byte(8'h86, a0); send_byte(8'h90, a1); send_byte(8'hBE, a2);
      chk("R5 no strobe after high byte", we_cnt - base, 0);
      send_byte(8'hEF, a3); m_stop;
      chk("R5 acks", {a0, a1, a2, a3}, 4'hF);
      chk("R5 one strobe", we_cnt - base, 1);
      chk("R5 word", last_data, 16'hBEEF);
   endtask

   task automatic t_extra;
      logic a0, a1, a2, a3;
      int base = we_cnt;
      m_start; send_byte(8'h86, a0); send_byte(8'h13, a1); send_byte(8'h11, a2);
      send_byte(8'h22, a3); m_stop;
      chk("R12 surplus nack", a3, 0);
      chk("R12 one strobe", we_cnt - base, 1);
      chk("R12 reg value", regs[8'h13], 16'h0011);
   endtask

   task automatic t_read16;
      logic a0, a1, a2;
      logic [7:0] hi, lo;
      m_start; send_byte(8'h86, a0); send_byte(8'h90, a1);
      m_start; send_byte(8'h87, a2);
      get_byte(hi, 1'b1); get_byte(lo, 1'b0);
      chk("R6 read addr ack", a2, 1);
      chk("R6 high byte", hi, 8'hBE);
      chk("R6 low byte", lo, 8'hEF);
      chk("R7 released after nack", sda_oe, 0);
      m_stop;
   endtask

   task automatic t_read8;
      logic a0, a1, a2;
      logic [7:0] v, w;
      m_start; send_byte(8'h86, a0); send_byte(8'h12, a1);
      m_start; send_byte(8'h87, a2);
      get_byte(v, 1'b1);
      chk("R6 narrow byte", v, 8'hA5);
      get_byte(w, 1'b0);
      chk("R7 nothing driven past last byte", w, 8'hFF);
      m_stop;
   endtask

   task automatic t_stop_kill;
      logic a0, a1, a2;
      m_start; send_byte(8'h86, a0); send_byte(8'h90, a1); m_stop;
      m_start; send_byte(8'h87, a2); m_stop;
      chk("R8 read after stop nacked", a2, 0);
      chk("R8 sda released", sda_oe, 0);
   endtask

   task automatic t_abort;
      logic a0, a1, a2, a3;
      int base = we_cnt;
      m_start; send_byte(8'h86, a0); send_byte(8'h91, a1); send_byte(8'h12, a2); m_stop;
      chk("R9 stop drops half word", we_cnt - base, 0);
      m_start; send_byte(8'h86, a0); send_byte(8'h92, a1); send_byte(8'h77, a2);
      m_start; send_byte(8'h86, a0); send_byte(8'h92, a1); send_byte(8'hAB, a2);
      send_byte(8'hCD, a3); m_stop;
      chk("R9 start drops half word", we_cnt - base, 1);
      chk("R9 fresh word", last_data, 16'hABCD);
   endtask

   task automatic t_stretch;
      logic a0, a1, a2;
      int base = we_cnt;
      hold = 1'b1;
      fork
         begin
            m_start; send_byte(8'h86, a0); send_byte(8'h14, a1); send_byte(8'h3C, a2); m_stop;
         end
         begin
            repeat (120) @(negedge clk);
            chk("R10 scl held", scl_oe, 1);
            chk("R10 bus low", scl_bus, 0);
            hold = 1'b0;
         end
      join
      chk("R10 transfer completes", {a0, a1, a2}, 3'b111);
      chk("R10 strobe", we_cnt - base, 1);
      chk("R10 scl free", scl_oe, 0);
   endtask

   task automatic t_strap;
      logic a0, a1;
      do_reset(1'b0);
      strap = 1'b1;
      repeat (4) @(negedge clk);
      m_start; send_byte(8'h8E, a0); m_stop;
      m_start; send_byte(8'h86, a1); m_stop;
      chk("R2 late strap ignored", a0, 0);
      chk("R2 low address kept", a1, 1);
      do_reset(1'b1);
      m_start; send_byte(8'h8E, a0); m_stop;
      m_start; send_byte(8'h86, a1); m_stop;
      chk("R1 high address acked", a0, 1);
      chk("R1 low address nacked", a1, 0);
      m_start; send_byte(8'hA0, a0); m_stop;
      chk("R1 foreign address nacked", a0, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      report;
      $finish;
   end

   initial begin
      do_reset(1'b0);
      t_reset;
      t_write8;
      t_write16;
      t_extra;
      t_read16;
      t_read8;
      t_stop_kill;
      t_abort;
      t_stretch;
      t_strap;
      report;
      $finish;
   end
endmodule